// File: doc/BRIEF.md
# Signed Index Limit Checker

This execution unit decides whether a signed array index lies between a lower and an upper limit. The two limits are stored next to each other in memory. A caller supplies the index, the byte address of the limit pair, an operand width (16 or 32 bits), a flag telling whether the second operand was encoded as a register, a real-mode flag and the address of the checking instruction. The unit then fetches both limits itself over a word-read port and compares them with the index. It finishes with a single-cycle completion pulse that reports either a pass or a fault. A fault carries an exception vector and the instruction's own address, so that the faulting instruction can be restarted.

Two faults are found before any memory traffic. A register-encoded second operand gives an invalid-opcode fault. In real mode, a limit pair that does not lie wholly inside the first 64 KiB gives an address-range fault. Only one fault is reported per request, taken in a fixed priority order. A passing check yields nothing except its completion. The outcome is always held back until a fixed minimum latency has elapsed.

Top module: `range_guard`

## Requirements
- R1: With `wideOp`=1, the index and both limits are 32-bit two's-complement values. The check passes only when lower <= index <= upper, with both ends included.
- R2: With `wideOp`=0, only bits 15:0 of the index and of each returned memory word are used, each read as a signed 16-bit value. The upper limit is read from the pair address plus 2.
- R3: With `wideOp`=1, the lower limit is read from the pair address and the upper limit from the pair address plus 4. This makes exactly two memory transactions, lower first.
- R4: An index outside the limits completes with `fault`=1, `vector`=5 and `faultAddr` equal to `instrAddr`.
- R5: When `regOperand`=1, the request completes with `fault`=1 and `vector`=6, and `memReq` is never raised.
- R6: When `realMode`=1 and the limit pair (4 bytes when narrow, 8 bytes when wide) would reach past byte address 0xFFFF, the request completes with `fault`=1 and `vector`=13 and makes no memory read. The same pair address with `realMode`=0 is read normally.
- R7: Faults are prioritised in this order: register operand (6) first, then address range (13), then bounds (5). Exactly one outcome is reported per request.
- R8: A passing check completes with `pass`=1, `fault`=0, `vector`=0 and `faultAddr`=0.
- R9: `done` rises exactly LATENCY (default 10) clock edges after the edge that accepts `startReq`, whatever the outcome, provided memory answers within a few cycles. Slow memory lengthens this by the stall cycles.
- R10: `done` is a single-cycle pulse. Outside that cycle, `pass`, `fault`, `vector` and `faultAddr` are all zero.
- R11: A `startReq` raised while `busy` is high is ignored. The running request finishes with its own result, and no extra completion follows.
- R12: A synchronous active-high `rst` returns the unit to idle (`busy`=0, `memReq`=0, `done`=0). Any request in flight is dropped without completing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| startReq | input | 1 | Request a check (accepted while idle) |
| indexIn | input | 32 | Signed index value |
| limitAddr | input | 32 | Byte address of the lower limit |
| wideOp | input | 1 | 1 = 32-bit operands, 0 = 16-bit operands |
| regOperand | input | 1 | Second operand was encoded as a register |
| realMode | input | 1 | Apply the 64 KiB real-mode range check |
| instrAddr | input | 32 | Address of the checking instruction |
| memReq | output | 1 | Memory read request, held until `memValid` |
| memAddr | output | 32 | Byte address of the read |
| memValid | input | 1 | Read data valid |
| memData | input | 32 | Returned read word |
| busy | output | 1 | A request is in flight |
| done | output | 1 | Completion pulse |
| pass | output | 1 | Index within limits |
| fault | output | 1 | A fault was raised |
| vector | output | 8 | Exception vector (5, 6 or 13), 0 on pass |
| faultAddr | output | 32 | Instruction address on fault, 0 on pass |

## Verification
The bench works on the edges of each limit. It tries an index equal to the lower limit, equal to the upper limit and one past the upper limit. It also tries negative limits, where an unsigned comparison would pass a negative index or reject a valid one.

In narrow mode, the upper half of the index and of the returned word is filled with garbage. A design that skips the sign extension, or reads the upper limit at offset 4, then gives the wrong verdict or the wrong address.

Real-mode pair addresses are placed one byte on either side of the 64 KiB edge for both widths, to catch an off-by-one in the range test. Combined faults check that the register fault wins over the range fault, and that both win over the bounds fault, with no memory read.

Three further cases are covered: latency padding under slow memory, a start pulse while busy, and a reset in mid-operation. These catch a unit that finishes early, accepts a second request, or emits a stray completion.

// File: rtl/range_guard_pkg.sv
package range_guard_pkg;

  typedef enum logic [1:0] {
    KIND_NONE  = 2'd0,
    KIND_INVOP = 2'd1,
    KIND_ADDR  = 2'd2
  } faultKind_e;

  typedef struct packed {
    logic load;
    logic capLo;
    logic capHi;
    logic selHi;
    logic emit;
  } dpCtl_t;

endpackage

// File: rtl/range_guard_dp.sv
module range_guard_dp
  import range_guard_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 32,
  parameter int VEC_W     = 8,
  parameter int VEC_BOUND = 5,
  parameter int VEC_INVOP = 6,
  parameter int VEC_ADDR  = 13,
  parameter int REAL_SPAN = 65536
) (
  input  logic              clk,
  input  logic              rst,
  input  dpCtl_t            ctl,
  input  logic [DATA_W-1:0] indexIn,
  input  logic [ADDR_W-1:0] limitAddr,
  input  logic              wideOp,
  input  logic              regOperand,
  input  logic              realMode,
  input  logic [ADDR_W-1:0] instrAddr,
  input  logic [DATA_W-1:0] memData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              preFault,
  output logic              done,
  output logic              pass,
  output logic              fault,
  output logic [VEC_W-1:0]  vector,
  output logic [ADDR_W-1:0] faultAddr
);

  localparam int HALF_W = DATA_W / 2;
  localparam logic [ADDR_W-1:0] WIDE_STEP   = ADDR_W'(DATA_W / 8);
  localparam logic [ADDR_W-1:0] NARROW_STEP = ADDR_W'(HALF_W / 8);
  localparam logic [ADDR_W:0]   WIDE_PAIR   = (ADDR_W+1)'(2 * (DATA_W / 8));
  localparam logic [ADDR_W:0]   NARROW_PAIR = (ADDR_W+1)'(2 * (HALF_W / 8));
  localparam logic [ADDR_W:0]   SPAN_END    = (ADDR_W+1)'(REAL_SPAN);

  function automatic logic [DATA_W-1:0] widen(input logic [DATA_W-1:0] v, input logic w);
    return w ? v : {{HALF_W{v[HALF_W-1]}}, v[HALF_W-1:0]};
  endfunction

  logic [DATA_W-1:0] idxR, loR, hiR;
  logic [ADDR_W-1:0] baseR, instrR;
  logic              wideR;
  faultKind_e        kindR, kindNext;
  logic [ADDR_W:0]   pairEnd;
  logic              rangeBad, inLimits;
  logic [DATA_W-1:0] idxX, loX, hiX;

  // Classification of faults that need no memory access, in priority order
  always_comb begin
    pairEnd  = {1'b0, limitAddr} + (wideOp ? WIDE_PAIR : NARROW_PAIR);
    rangeBad = realMode && (pairEnd > SPAN_END);
    if (regOperand)    kindNext = KIND_INVOP;
    else if (rangeBad) kindNext = KIND_ADDR;
    else               kindNext = KIND_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idxR   <= '0;
      baseR  <= '0;
      instrR <= '0;
      wideR  <= 1'b0;
      kindR  <= KIND_NONE;
      loR    <= '0;
      hiR    <= '0;
    end else begin
      if (ctl.load) begin
        idxR   <= indexIn;
        baseR  <= limitAddr;
        instrR <= instrAddr;
        wideR  <= wideOp;
        kindR  <= kindNext;
      end
      if (ctl.capLo) loR <= memData;
      if (ctl.capHi) hiR <= memData;
    end
  end

  assign preFault = (kindR != KIND_NONE);
  assign memAddr  = ctl.selHi ? baseR + (wideR ? WIDE_STEP : NARROW_STEP) : baseR;

  always_comb begin
    idxX     = widen(idxR, wideR);
    loX      = widen(loR, wideR);
    hiX      = widen(hiR, wideR);
    inLimits = ($signed(idxX) >= $signed(loX)) && ($signed(idxX) <= $signed(hiX));
  end

  always_ff @(posedge clk) begin
    if (rst || !ctl.emit) begin
      done      <= 1'b0;
      pass      <= 1'b0;
      fault     <= 1'b0;
      vector    <= '0;
      faultAddr <= '0;
    end else begin
      done <= 1'b1;
      case (kindR)
        KIND_INVOP: begin
          fault     <= 1'b1;
          vector    <= VEC_W'(VEC_INVOP);
          faultAddr <= instrR;
        end
        KIND_ADDR: begin
          fault     <= 1'b1;
          vector    <= VEC_W'(VEC_ADDR);
          faultAddr <= instrR;
        end
        default: begin
          if (inLimits) begin
            pass <= 1'b1;
          end else begin
            fault     <= 1'b1;
            vector    <= VEC_W'(VEC_BOUND);
            faultAddr <= instrR;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/range_guard_ctrl.sv
module range_guard_ctrl
  import range_guard_pkg::*;
#(
  parameter int LATENCY = 10
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   startReq,
  input  logic   memValid,
  input  logic   preFault,
  output dpCtl_t ctl,
  output logic   memReq,
  output logic   busy
);

  localparam int CNT_W = $clog2(LATENCY + 1);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(LATENCY);

  typedef enum logic [2:0] {
    ST_IDLE, ST_SORT, ST_RDLO, ST_RDHI, ST_FINISH
  } state_e;

  state_e           state, stateNext;
  logic [CNT_W-1:0] cycleCnt;

  always_comb begin
    stateNext = state;
    ctl       = '0;
    memReq    = 1'b0;
    case (state)
      ST_IDLE: begin
        if (startReq) begin
          ctl.load  = 1'b1;
          stateNext = ST_SORT;
        end
      end
      ST_SORT: stateNext = preFault ? ST_FINISH : ST_RDLO;
      ST_RDLO: begin
        memReq = 1'b1;
        if (memValid) begin
          ctl.capLo = 1'b1;
          stateNext = ST_RDHI;
        end
      end
      ST_RDHI: begin
        memReq    = 1'b1;
        ctl.selHi = 1'b1;
        if (memValid) begin
          ctl.capHi = 1'b1;
          stateNext = ST_FINISH;
        end
      end
      ST_FINISH: begin
        if (cycleCnt >= CNT_TOP) begin
          ctl.emit  = 1'b1;
          stateNext = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cycleCnt <= '0;
    end else begin
      state <= stateNext;
      if (ctl.load)
        cycleCnt <= CNT_W'(1);
      else if (state != ST_IDLE && cycleCnt < CNT_TOP)
        cycleCnt <= cycleCnt + CNT_W'(1);
    end
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/range_guard.sv
module range_guard
  import range_guard_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 32,
  parameter int VEC_W     = 8,
  parameter int LATENCY   = 10,
  parameter int VEC_BOUND = 5,
  parameter int VEC_INVOP = 6,
  parameter int VEC_ADDR  = 13,
  parameter int REAL_SPAN = 65536
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              startReq,
  input  logic [DATA_W-1:0] indexIn,
  input  logic [ADDR_W-1:0] limitAddr,
  input  logic              wideOp,
  input  logic              regOperand,
  input  logic              realMode,
  input  logic [ADDR_W-1:0] instrAddr,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memValid,
  input  logic [DATA_W-1:0] memData,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic              fault,
  output logic [VEC_W-1:0]  vector,
  output logic [ADDR_W-1:0] faultAddr
);

  dpCtl_t ctl;
  logic   preFault;

  range_guard_ctrl #(.LATENCY(LATENCY)) ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .startReq (startReq),
    .memValid (memValid),
    .preFault (preFault),
    .ctl      (ctl),
    .memReq   (memReq),
    .busy     (busy)
  );

  range_guard_dp #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .VEC_W(VEC_W),
    .VEC_BOUND(VEC_BOUND), .VEC_INVOP(VEC_INVOP), .VEC_ADDR(VEC_ADDR),
    .REAL_SPAN(REAL_SPAN)
  ) dp_i (
    .clk        (clk),
    .rst        (rst),
    .ctl        (ctl),
    .indexIn    (indexIn),
    .limitAddr  (limitAddr),
    .wideOp     (wideOp),
    .regOperand (regOperand),
    .realMode   (realMode),
    .instrAddr  (instrAddr),
    .memData    (memData),
    .memAddr    (memAddr),
    .preFault   (preFault),
    .done       (done),
    .pass       (pass),
    .fault      (fault),
    .vector     (vector),
    .faultAddr  (faultAddr)
  );

endmodule

// File: rtl/range_guard_sva.sv
module range_guard_sva #(
  parameter int VEC_W   = 8,
  parameter int LATENCY = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             startReq,
  input logic             regOperand,
  input logic             memReq,
  input logic             busy,
  input logic             done,
  input logic             pass,
  input logic             fault,
  input logic [VEC_W-1:0] vector
);

  logic        accept;
  logic        regPending;
  logic [15:0] sinceStart;

  assign accept = startReq && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      regPending <= 1'b0;
      sinceStart <= '0;
    end else begin
      if (accept) regPending <= regOperand;
      else if (done) regPending <= 1'b0;
      if (accept) sinceStart <= 16'd1;
      else if (busy && sinceStart != 16'hFFFF) sinceStart <= sinceStart + 16'd1;
    end
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R10
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst) done |-> (pass ^ fault)); // R7
  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (rst) !done |-> (!pass && !fault && vector == '0)); // R10
  AST_VALID_VECTOR: assert property (@(posedge clk) disable iff (rst)
    (done && fault) |-> (vector == VEC_W'(5) || vector == VEC_W'(6) || vector == VEC_W'(13))); // R4
  AST_NO_READ_ON_REG: assert property (@(posedge clk) disable iff (rst) regPending |-> !memReq); // R5
  AST_MIN_LATENCY: assert property (@(posedge clk) disable iff (rst) done |-> (sinceStart >= 16'(LATENCY))); // R9
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst) accept |=> busy); // R11
  AST_DONE_FREES: assert property (@(posedge clk) disable iff (rst) done |-> !busy); // R11
  AST_REQ_WHEN_BUSY: assert property (@(posedge clk) disable iff (rst) memReq |-> busy); // R12

endmodule

bind range_guard range_guard_sva #(.VEC_W(VEC_W), .LATENCY(LATENCY)) sva_i (
  .clk        (clk),
  .rst        (rst),
  .startReq   (startReq),
  .regOperand (regOperand),
  .memReq     (memReq),
  .busy       (busy),
  .done       (done),
  .pass       (pass),
  .fault      (fault),
  .vector     (vector)
);

// File: tb/range_guard_tb_top.sv
module range_guard_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        startReq = 1'b0;
  logic [31:0] indexIn = '0;
  logic [31:0] limitAddr = '0;
  logic        wideOp = 1'b0;
  logic        regOperand = 1'b0;
  logic        realMode = 1'b0;
  logic [31:0] instrAddr = '0;
  logic        memReq;
  logic [31:0] memAddr;
  logic        memValid = 1'b0;
  logic [31:0] memData = '0;
  logic        busy, done, pass, fault;
  logic [7:0]  vector;
  logic [31:0] faultAddr;

  int testsRun = 0;
  int testsFailed = 0;

  always #5 clk = ~clk;

  range_guard dut_i (
    .clk(clk), .rst(rst), .startReq(startReq), .indexIn(indexIn),
    .limitAddr(limitAddr), .wideOp(wideOp), .regOperand(regOperand),
    .realMode(realMode), .instrAddr(instrAddr), .memReq(memReq),
    .memAddr(memAddr), .memValid(memValid), .memData(memData),
    .busy(busy), .done(done), .pass(pass), .fault(fault),
    .vector(vector), .faultAddr(faultAddr)
  );

  // Byte-addressed memory model, low 8 address bits, optional stall
  logic [7:0]  mem [256];
  int          stallCycles = 0;
  int          waitCnt = 0;
  int          txnTotal = 0;
  logic [31:0] prevAddr = '0;
  logic [31:0] curAddr = '0;

  always @(posedge clk) begin
    if (memReq && !memValid) begin
      if (waitCnt < stallCycles) waitCnt <= waitCnt + 1;
      else begin
        memValid <= 1'b1;
        waitCnt  <= 0;
        memData  <= {mem[8'(memAddr[7:0] + 8'd3)], mem[8'(memAddr[7:0] + 8'd2)],
                     mem[8'(memAddr[7:0] + 8'd1)], mem[memAddr[7:0]]};
      end
    end else begin
      memValid <= 1'b0;
    end
    if (memReq && memValid) begin
      txnTotal <= txnTotal + 1;
      prevAddr <= curAddr;
      curAddr  <= memAddr;
    end
  end

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic putLimits(input logic w, input logic [31:0] ad, input logic [31:0] lo, input logic [31:0] hi);
    int step = w ? 4 : 2;
    for (int b = 0; b < step; b++) begin
      mem[8'(ad[7:0] + 8'(b))]        = lo[8*b +: 8];
      mem[8'(ad[7:0] + 8'(step + b))] = hi[8*b +: 8];
    end
  endtask

  logic        capPass, capFault;
  logic [7:0]  capVec;
  logic [31:0] capAddr;

  // Launch one request; returns edges from accept to done (0 if none seen)
  task automatic runOp(input logic w, input logic rg, input logic rm,
                       input logic [31:0] idx, input logic [31:0] ad,
                       input logic [31:0] ia, input int pokeAt, output int n);
    @(negedge clk);
    wideOp = w; regOperand = rg; realMode = rm;
    indexIn = idx; limitAddr = ad; instrAddr = ia;
    startReq = 1'b1;
    @(posedge clk);
    @(negedge clk);
    startReq = 1'b0;
    n = 0;
    capPass = 1'b0; capFault = 1'b0; capVec = '0; capAddr = '0;
    for (int k = 1; k <= 200; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (k == pokeAt) begin
        startReq = 1'b1; regOperand = 1'b1;
      end else if (k == pokeAt + 1) begin
        startReq = 1'b0; regOperand = rg;
      end
      if (done) begin
        n = k;
        capPass = pass; capFault = fault; capVec = vector; capAddr = faultAddr;
        break;
      end
    end
  endtask

  typedef struct packed {
    logic        w;
    logic        rg;
    logic        rm;
    logic [31:0] idx;
    logic [31:0] ad;
    logic [31:0] lo;
    logic [31:0] hi;
    logic [7:0]  vec;
  } tv_t;

  localparam int NTV = 18;
  localparam tv_t TV [NTV] = '{
    '{1'b1, 1'b0, 1'b0, 32'd5,          32'h0000_0010, 32'd0,          32'd10,         8'd0},  // R1 inside
    '{1'b1, 1'b0, 1'b0, 32'd0,          32'h0000_0020, 32'd0,          32'd10,         8'd0},  // R1 lower edge
    '{1'b1, 1'b0, 1'b0, 32'd10,         32'h0000_0030, 32'd0,          32'd10,         8'd0},  // R1 upper edge
    '{1'b1, 1'b0, 1'b0, 32'd11,         32'h0000_0040, 32'd0,          32'd10,         8'd5},  // R4 above
    '{1'b1, 1'b0, 1'b0, 32'hFFFF_FFFF,  32'h0000_0050, 32'd0,          32'd10,         8'd5},  // R4 negative below
    '{1'b1, 1'b0, 1'b0, 32'hFFFF_FFFB,  32'h0000_0060, 32'hFFFF_FFF6,  32'hFFFF_FFFE,  8'd0},  // R1 negative limits
    '{1'b1, 1'b0, 1'b0, 32'h7FFF_FFFF,  32'h0000_0070, 32'hFFFF_FFFF,  32'h7FFF_FFFF,  8'd0},  // R1 extreme
    '{1'b0, 1'b0, 1'b0, 32'h1234_FFFF,  32'h0000_0080, 32'h0000_FFF0,  32'd5,          8'd0},  // R2 narrow signed
    '{1'b0, 1'b0, 1'b0, 32'h0000_8000,  32'h0000_0090, 32'h0000_8000,  32'd0,          8'd0},  // R2 narrow min
    '{1'b0, 1'b0, 1'b0, 32'h0000_0006,  32'h0000_00A0, 32'd0,          32'd5,          8'd5},  // R2 narrow above
    '{1'b1, 1'b1, 1'b0, 32'd5,          32'h0000_00B0, 32'd0,          32'd10,         8'd6},  // R5
    '{1'b1, 1'b1, 1'b1, 32'd99,         32'h0000_FFFF, 32'd0,          32'd10,         8'd6},  // R7 reg beats range
    '{1'b0, 1'b0, 1'b1, 32'd3,          32'h0000_FFFD, 32'd0,          32'd7,          8'd13}, // R6 narrow over
    '{1'b0, 1'b0, 1'b1, 32'd3,          32'h0000_FFFC, 32'd0,          32'd7,          8'd0},  // R6 narrow fits
    '{1'b1, 1'b0, 1'b1, 32'd3,          32'h0000_FFF9, 32'd0,          32'd7,          8'd13}, // R6 wide over
    '{1'b1, 1'b0, 1'b1, 32'd3,          32'h0000_FFF8, 32'd0,          32'd7,          8'd0},  // R6 wide fits
    '{1'b1, 1'b0, 1'b1, 32'd100,        32'h0000_FFF9, 32'd0,          32'd7,          8'd13}, // R7 range beats bounds
    '{1'b1, 1'b0, 1'b0, 32'd3,          32'h0001_0000, 32'd0,          32'd7,          8'd0}   // R6 not in real mode
  };

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    testsFailed++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin : main
    int n;
    int base;
    int extraDone;
    for (int a = 0; a < 256; a++) mem[a] = 8'hA5;

    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!busy && !done && !memReq && !pass && !fault, "R12 reset idle",
          {28'd0, busy, done, memReq, fault}, 32'd0);
    rst = 1'b0;

    // Table walk
    for (int i = 0; i < NTV; i++) begin
      logic [31:0] ia;
      ia = 32'h0000_1000 + 32'(i * 4);
      putLimits(TV[i].w, TV[i].ad, TV[i].lo, TV[i].hi);
      base = txnTotal;
      runOp(TV[i].w, TV[i].rg, TV[i].rm, TV[i].idx, TV[i].ad, ia, -5, n);
      check(n == 10, $sformatf("R9 latency vec%0d", i), 32'(n), 32'd10);
      if (TV[i].vec == 8'd0) begin
        check(capPass && !capFault && capVec == 0 && capAddr == 0,
              $sformatf("R8 pass vec%0d", i), {capPass, capFault, capVec, capAddr[21:0]}, {1'b1, 31'd0});
      end else begin
        check(capFault && !capPass && capVec == TV[i].vec,
              $sformatf("R4 R7 fault vector vec%0d", i), {24'd0, capVec}, {24'd0, TV[i].vec});
        check(capAddr == ia, $sformatf("R4 fault address vec%0d", i), capAddr, ia);
      end
      if (TV[i].vec == 8'd6 || TV[i].vec == 8'd13) begin
        check(txnTotal == base, $sformatf("R5 R6 no read vec%0d", i), 32'(txnTotal - base), 32'd0);
      end else begin
        check(txnTotal == base + 2, $sformatf("R3 read count vec%0d", i), 32'(txnTotal - base), 32'd2);
        check(prevAddr == TV[i].ad, $sformatf("R3 lower address vec%0d", i), prevAddr, TV[i].ad);
        check(curAddr == TV[i].ad + (TV[i].w ? 32'd4 : 32'd2),
              $sformatf("R2 R3 upper address vec%0d", i), curAddr, TV[i].ad + (TV[i].w ? 32'd4 : 32'd2));
      end
      @(negedge clk);
      check(!done && !pass && !fault && vector == 0 && faultAddr == 0,
            $sformatf("R10 pulse ends vec%0d", i), {done, pass, fault, vector, faultAddr[20:0]}, 32'd0);
    end

    // R9: slow memory stretches the latency to 6 + 2*stall edges
    stallCycles = 5;
    putLimits(1'b1, 32'h20, 32'd0, 32'd10);
    runOp(1'b1, 1'b0, 1'b0, 32'd4, 32'h20, 32'h2000, -5, n);
    check(n == 16, "R9 stalled latency", 32'(n), 32'd16);
    check(capPass, "R9 stalled result pass", {31'd0, capPass}, 32'd1);
    stallCycles = 0;

    // R11: start while busy is ignored
    putLimits(1'b1, 32'h30, 32'd0, 32'd10);
    runOp(1'b1, 1'b0, 1'b0, 32'd4, 32'h30, 32'h3000, 3, n);
    check(n == 10 && capPass && !capFault, "R11 busy start ignored",
          {24'd0, capVec}, 32'd0);
    extraDone = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (done) extraDone++;
    end
    check(extraDone == 0, "R11 no extra completion", 32'(extraDone), 32'd0);

    // R12: reset in flight drops the request
    @(negedge clk);
    wideOp = 1'b1; regOperand = 1'b0; realMode = 1'b0;
    indexIn = 32'd4; limitAddr = 32'h30; instrAddr = 32'h4000;
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(!busy && !done && !memReq, "R12 reset mid-operation",
          {29'd0, busy, done, memReq}, 32'd0);
    rst = 1'b0;
    extraDone = 0;
    for (int k = 0; k < 15; k++) begin
      @(negedge clk);
      if (done || busy) extraDone++;
    end
    check(extraDone == 0, "R12 dropped request stays silent", 32'(extraDone), 32'd0);

    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule